// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic unit of a small 8-bit accumulator processor. Each request carries a group select, a 3-bit operation code, the accumulator value, a second operand and the current status flags. The response carries the 8-bit result, the new flags and a bit that says whether the accumulator should be written. The first group holds the logic operations, add with carry, subtract with borrow and compare. The second group holds the one-bit shifts and rotates of the accumulator, plus increment and decrement. Decimal arithmetic, operand fetch and address generation are handled elsewhere.

Requests enter on a valid/ready port. Results leave from one output register with its own valid/ready port. `in_ready` is high when the output register is empty, or when its content is taken in the same cycle. A request is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. Its response is visible from the next cycle. The response stays unchanged until a rising edge where `out_valid` and `out_ready` are both high. A stalled consumer therefore stops new requests from being accepted.

The flags bus is packed as bit 0 carry (C), bit 1 zero (Z), bit 2 overflow (V) and bit 3 negative (N). This packing applies to both `in_flags` and `out_flags`.

Top module: `acc_alu8`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An accepted request raises `out_valid` in the following cycle. While `out_valid` is high and `out_ready` is low, `out_res`, `out_flags` and `out_wr_acc` hold their values.
- R2: With `in_grp`=0, codes 0, 1 and 2 give the accumulator ORed, ANDed or XORed with the operand. `out_wr_acc` is 1, and C and V are passed through unchanged.
- R3: With `in_grp`=0 and code 3 (add with carry), the result is the low 8 bits of A + operand + C. C is set when that sum exceeds 0xFF. V is set when the signed sum falls outside -128..127. `out_wr_acc` is 1.
- R4: With `in_grp`=0 and code 7 (subtract with borrow), the result is A - operand - (1 - C). C is cleared exactly when that difference is negative. V is set when the signed difference falls outside -128..127. `out_wr_acc` is 1.
- R5: With `in_grp`=0 and code 6 (compare), C is A >= operand (unsigned), Z is A == operand and N is bit 7 of A - operand. V is unchanged, `out_res` equals A and `out_wr_acc` is 0.
- R6: With `in_grp`=1, code 0 shifts left and code 2 shifts right, each filling the vacated bit with 0. Code 1 rotates left and code 3 rotates right through the incoming C. Left forms take C from old bit 7, right forms take C from old bit 0, V is unchanged and `out_wr_acc` is 1.
- R7: With `in_grp`=1, code 6 decrements A (0x00 wraps to 0xFF) and code 7 increments A (0xFF wraps to 0x00). C and V are unchanged and `out_wr_acc` is 1.
- R8: Whenever `out_wr_acc` is 1, Z is set exactly when `out_res` is zero and N equals bit 7 of `out_res`.
- R9: In either group, codes 4 and 5 return A as the result, return all four flags unchanged and drive `out_wr_acc` to 0.
- R10: In group 1 the operand input has no effect on the result or on the flags.
- R11: During reset and right after it, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_grp | input | 1 | 0 = logic/arithmetic group, 1 = shift/step group |
| in_op | input | 3 | Operation code within the group |
| in_acc | input | 8 | Accumulator value |
| in_opnd | input | 8 | Second operand (group 0 only) |
| in_flags | input | 4 | Incoming flags {N,V,Z,C} |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Consumer takes the response |
| out_res | output | 8 | Result value |
| out_flags | output | 4 | Updated flags {N,V,Z,C} |
| out_wr_acc | output | 1 | Accumulator should take out_res |

## Verification
Directed cases cover the points where the carry and overflow rules diverge:
- 0x7F+1 overflows without a carry, while 0xFF+1 carries without an overflow.
- 0x00-1 with and without borrow.
- Compare with equal, smaller and larger operands.
- The 0x00 and 0xFF wrap of the step operations.
- A rotate that moves the incoming carry into the vacated bit.
- Codes 4 and 5, which separate pass-through from a real operation.

Seeded random requests with random incoming flags cover every code in both groups. They show whether each code preserves C and V or overwrites them. A stalled-consumer sequence shows that the response holds and that new requests wait, and a repeated group 1 request with a different operand shows that the operand is ignored.

// File: rtl/acc_alu8_pkg.sv
package acc_alu8_pkg;
  localparam int FLAG_BITS = 4;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FV = 2;
  localparam int FN = 3;

  typedef enum logic [2:0] {
    AR_OR  = 3'd0,
    AR_AND = 3'd1,
    AR_XOR = 3'd2,
    AR_ADD = 3'd3,
    AR_NU4 = 3'd4,
    AR_NU5 = 3'd5,
    AR_CMP = 3'd6,
    AR_SUB = 3'd7
  } arith_op_e;

  typedef enum logic [2:0] {
    SH_SHL = 3'd0,
    SH_ROL = 3'd1,
    SH_SHR = 3'd2,
    SH_ROR = 3'd3,
    SH_NU4 = 3'd4,
    SH_NU5 = 3'd5,
    SH_DEC = 3'd6,
    SH_INC = 3'd7
  } step_op_e;
endpackage

// File: rtl/alu8_arith_unit.sv
module alu8_arith_unit
  import acc_alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [2:0]           op,
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  input  logic [FLAG_BITS-1:0] fin,
  output logic [W-1:0]         res,
  output logic [FLAG_BITS-1:0] fout,
  output logic                 wr
);
  arith_op_e   code;
  logic        use_inv;
  logic        cin;
  logic [W-1:0] b_eff;
  logic [W:0]  sum;
  logic        ovf;

  assign code    = arith_op_e'(op);
  assign use_inv = (code == AR_SUB) || (code == AR_CMP);
  assign b_eff   = use_inv ? ~b : b;
  assign cin     = (code == AR_CMP) ? 1'b1 : fin[FC];
  // single shared adder for add, subtract and compare
  assign sum     = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  assign ovf     = ((sum[W-1:0] ^ b_eff) & (sum[W-1:0] ^ a)) >> (W-1) != '0;

  always_comb begin
    res  = a;
    fout = fin;
    wr   = 1'b0;
    unique case (code)
      AR_OR:  begin res = a | b; wr = 1'b1; end
      AR_AND: begin res = a & b; wr = 1'b1; end
      AR_XOR: begin res = a ^ b; wr = 1'b1; end
      AR_ADD, AR_SUB: begin
        res      = sum[W-1:0];
        wr       = 1'b1;
        fout[FC] = sum[W];
        fout[FV] = ovf;
      end
      AR_CMP: begin
        fout[FC] = sum[W];
        fout[FZ] = (a == b);
        fout[FN] = sum[W-1];
      end
      default: begin end
    endcase
    if (wr) begin
      fout[FZ] = (res == '0);
      fout[FN] = res[W-1];
    end
  end
endmodule

// File: rtl/alu8_step_unit.sv
module alu8_step_unit
  import acc_alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [2:0]           op,
  input  logic [W-1:0]         a,
  input  logic [FLAG_BITS-1:0] fin,
  output logic [W-1:0]         res,
  output logic [FLAG_BITS-1:0] fout,
  output logic                 wr
);
  step_op_e code;
  assign code = step_op_e'(op);

  always_comb begin
    res  = a;
    fout = fin;
    wr   = 1'b0;
    unique case (code)
      SH_SHL: begin res = {a[W-2:0], 1'b0};     fout[FC] = a[W-1]; wr = 1'b1; end
      SH_ROL: begin res = {a[W-2:0], fin[FC]};  fout[FC] = a[W-1]; wr = 1'b1; end
      SH_SHR: begin res = {1'b0, a[W-1:1]};     fout[FC] = a[0];   wr = 1'b1; end
      SH_ROR: begin res = {fin[FC], a[W-1:1]};  fout[FC] = a[0];   wr = 1'b1; end
      SH_DEC: begin res = a - 1'b1; wr = 1'b1; end
      SH_INC: begin res = a + 1'b1; wr = 1'b1; end
      default: begin end
    endcase
    if (wr) begin
      fout[FZ] = (res == '0);
      fout[FN] = res[W-1];
    end
  end
endmodule

// File: rtl/alu8_out_reg.sv
module alu8_out_reg #(
  parameter int PW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R1
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R1
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
  import acc_alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_grp,
  input  logic [2:0]           in_op,
  input  logic [W-1:0]         in_acc,
  input  logic [W-1:0]         in_opnd,
  input  logic [FLAG_BITS-1:0] in_flags,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [W-1:0]         out_res,
  output logic [FLAG_BITS-1:0] out_flags,
  output logic                 out_wr_acc
);
  localparam int PW = W + FLAG_BITS + 1;

  logic [W-1:0]         ar_res, st_res, sel_res;
  logic [FLAG_BITS-1:0] ar_flg, st_flg, sel_flg;
  logic                 ar_wr, st_wr, sel_wr;
  logic [PW-1:0]        pay_in, pay_out;

  alu8_arith_unit #(.W(W)) u_arith (
    .op(in_op), .a(in_acc), .b(in_opnd), .fin(in_flags),
    .res(ar_res), .fout(ar_flg), .wr(ar_wr)
  );

  alu8_step_unit #(.W(W)) u_step (
    .op(in_op), .a(in_acc), .fin(in_flags),
    .res(st_res), .fout(st_flg), .wr(st_wr)
  );

  assign sel_res = in_grp ? st_res : ar_res;
  assign sel_flg = in_grp ? st_flg : ar_flg;
  assign sel_wr  = in_grp ? st_wr  : ar_wr;
  assign pay_in  = {sel_wr, sel_flg, sel_res};

  alu8_out_reg #(.PW(PW)) u_oreg (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(pay_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(pay_out)
  );

  assign out_res    = pay_out[W-1:0];
  assign out_flags  = pay_out[W +: FLAG_BITS];
  assign out_wr_acc = pay_out[PW-1];

  AST_NZ_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_wr_acc |-> out_flags[FZ] == (out_res == '0) && out_flags[FN] == out_res[W-1]); // R8
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_grp && in_op == 3'd6 |=> !out_wr_acc && out_res == $past(in_acc)); // R5
  AST_STEP_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_grp && in_op[2:1] == 2'b11
    |=> out_flags[FC] == $past(in_flags[FC]) && out_flags[FV] == $past(in_flags[FV])); // R7
  AST_UNUSED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op[2:1] == 2'b10
    |=> out_flags == $past(in_flags) && out_res == $past(in_acc) && !out_wr_acc); // R9
  AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_grp && in_op <= 3'd2
    |=> out_flags[FC] == $past(in_flags[FC]) && out_flags[FV] == $past(in_flags[FV])); // R2
endmodule

// File: tb/acc_alu8_tb.sv
`timescale 1ns/1ps
module acc_alu8_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_grp = 1'b0;
  logic [2:0] in_op = '0;
  logic [7:0] in_acc = '0;
  logic [7:0] in_opnd = '0;
  logic [3:0] in_flags = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_res;
  logic [3:0] out_flags;
  logic       out_wr_acc;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  acc_alu8 u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_grp(in_grp), .in_op(in_op), .in_acc(in_acc), .in_opnd(in_opnd),
    .in_flags(in_flags), .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_flags(out_flags), .out_wr_acc(out_wr_acc)
  );

  // reference: returns {wr, N, V, Z, C, res}
  function automatic logic [12:0] model(input logic g, input logic [2:0] op,
                                        input logic [7:0] a, input logic [7:0] b,
                                        input logic [3:0] f);
    logic [7:0] r; logic c, z, v, n, w; int u, s;
    r = a; c = f[0]; z = f[1]; v = f[2]; n = f[3]; w = 1'b0;
    if (!g) begin
      case (op)
        3'd0: begin r = a | b; w = 1; end
        3'd1: begin r = a & b; w = 1; end
        3'd2: begin r = a ^ b; w = 1; end
        3'd3: begin
          u = int'(a) + int'(b) + int'(f[0]);
          s = int'($signed(a)) + int'($signed(b)) + int'(f[0]);
          r = u[7:0]; c = (u > 255); v = (s > 127 || s < -128); w = 1;
        end
        3'd7: begin
          u = int'(a) - int'(b) - (1 - int'(f[0]));
          s = int'($signed(a)) - int'($signed(b)) - (1 - int'(f[0]));
          r = u[7:0]; c = (u >= 0); v = (s > 127 || s < -128); w = 1;
        end
        3'd6: begin
          u = int'(a) - int'(b);
          c = (a >= b); z = (a == b); n = u[7];
        end
        default: ;
      endcase
    end else begin
      case (op)
        3'd0: begin r = a << 1; c = a[7]; w = 1; end
        3'd1: begin r = (a << 1) | {7'd0, f[0]}; c = a[7]; w = 1; end
        3'd2: begin r = a >> 1; c = a[0]; w = 1; end
        3'd3: begin r = (a >> 1) | {f[0], 7'd0}; c = a[0]; w = 1; end
        3'd6: begin r = (a == 8'h00) ? 8'hFF : a - 8'd1; w = 1; end
        3'd7: begin r = (a == 8'hFF) ? 8'h00 : a + 8'd1; w = 1; end
        default: ;
      endcase
    end
    if (w) begin z = (r == 8'h00); n = r[7]; end
    return {w, n, v, z, c, r};
  endfunction

  function automatic string tag_of(input logic g, input logic [2:0] op);
    if (op == 3'd4 || op == 3'd5) return "R9";
    if (!g) begin
      if (op <= 3'd2) return "R2";
      if (op == 3'd3) return "R3";
      if (op == 3'd6) return "R5";
      return "R4";
    end
    if (op <= 3'd3) return "R6";
    return "R7";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic g, input logic [2:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic [3:0] f, input string tag);
    logic [12:0] e;
    e = model(g, op, a, b, f);
    @(negedge clk);
    in_valid = 1; in_grp = g; in_op = op; in_acc = a; in_opnd = b; in_flags = f;
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check(tag, {18'd0, out_valid, out_wr_acc, out_flags, out_res}, {18'd0, 1'b1, e});
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [12:0] e;
    void'($urandom(32'd7391));
    repeat (3) @(negedge clk);
    check("R11", {30'd0, out_valid, in_ready}, 32'd1);
    rst_n = 1;
    @(negedge clk);
    check("R11", {30'd0, out_valid, in_ready}, 32'd1);

    // directed corners
    run_one(0, 3'd3, 8'h7F, 8'h01, 4'h0, "R3");
    run_one(0, 3'd3, 8'hFF, 8'h01, 4'h0, "R3");
    run_one(0, 3'd3, 8'h80, 8'h80, 4'h1, "R3");
    run_one(0, 3'd7, 8'h00, 8'h01, 4'h1, "R4");
    run_one(0, 3'd7, 8'h00, 8'h00, 4'h0, "R4");
    run_one(0, 3'd7, 8'h80, 8'h01, 4'h1, "R4");
    run_one(0, 3'd6, 8'h42, 8'h42, 4'h4, "R5");
    run_one(0, 3'd6, 8'h10, 8'h20, 4'h1, "R5");
    run_one(0, 3'd6, 8'hF0, 8'h01, 4'h0, "R5");
    run_one(0, 3'd1, 8'hF0, 8'h0F, 4'h5, "R2");
    run_one(1, 3'd0, 8'h80, 8'h00, 4'h0, "R6");
    run_one(1, 3'd3, 8'h01, 8'h00, 4'h1, "R6");
    run_one(1, 3'd1, 8'h7F, 8'h00, 4'h1, "R6");
    run_one(1, 3'd6, 8'h00, 8'h00, 4'h5, "R7");
    run_one(1, 3'd7, 8'hFF, 8'h00, 4'h4, "R7");
    run_one(0, 3'd4, 8'h00, 8'h33, 4'hA, "R9");
    run_one(1, 3'd5, 8'h99, 8'h33, 4'h5, "R9");
    run_one(0, 3'd2, 8'hAA, 8'hAA, 4'h0, "R8");
    // operand must not matter in group 1
    run_one(1, 3'd2, 8'h5A, 8'h00, 4'h0, "R10");
    run_one(1, 3'd2, 8'h5A, 8'hFF, 4'h0, "R10");

    // stalled consumer
    e = model(0, 3'd0, 8'h0C, 8'h30, 4'h0);
    @(negedge clk);
    out_ready = 0; in_valid = 1; in_grp = 0; in_op = 3'd0; in_acc = 8'h0C; in_opnd = 8'h30; in_flags = 4'h0;
    @(negedge clk);
    in_acc = 8'hFF; in_op = 3'd7;
    check("R1", {30'd0, out_valid, in_ready}, 32'd2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R1", {19'd0, out_wr_acc, out_flags, out_res}, {19'd0, e});
    end
    in_valid = 0; out_ready = 1;
    @(negedge clk);
    check("R1", {31'd0, out_valid}, 32'd0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic g; logic [2:0] op; logic [7:0] a, b; logic [3:0] f;
      g = 1'($urandom); op = 3'($urandom); a = 8'($urandom);
      b = 8'($urandom); f = 4'($urandom);
      if (i % 8 == 0) a = (i % 16 == 0) ? 8'hFF : 8'h00;
      run_one(g, op, a, b, f, tag_of(g, op));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule